// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the control address register of a microprogrammed control unit and decides, once per clock, which control-memory word is read next. The current microinstruction supplies a branch-type field, a condition-select field and a branch-address field. The instruction register supplies the opcode bits. A small set of status flags is also an input. From these, the sequencer loads the register from one of four places. It can step to the following word, load the branch target, jump to the start of the routine that belongs to the opcode, or resume at an address held in a single return register.

A branch or a call is made conditional by picking one status flag, or a constant one, through the condition select. When the picked value is 0, the sequencer steps on instead. A call that is taken saves the address after the calling word in the return register. That register is separate from control memory, because control memory cannot be written. The end of an instruction is coded as an unconditional branch back to the first word of the fetch routine.

Top module: `mseq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising edge, `car_o` loads FETCH_ADDR (default 0), and it keeps that value in the cycle after reset is released.
- R2: Reset also loads the return register with FETCH_ADDR, so a return executed first after reset leads to FETCH_ADDR.
- R3: `cond_sel_i` picks the branch condition: 0 is a constant 1, 1 is `status_i[0]` (carry), 2 is `status_i[1]` (sign), 3 is `status_i[2]` (indirect mode). Flags that are not selected have no effect.
- R4: With `br_type_i` = 0 (jump), a true condition loads `br_addr_i` into `car_o` at the next edge. A false condition loads `car_o`+1.
- R5: With `br_type_i` = 3 (map), `car_o` loads {0, opcode, 00}, that is, opcode×4 for the default widths. Each routine gets four words.
- R6: With `br_type_i` = 1 (call) and a true condition, `car_o` loads `br_addr_i`, and in the same edge the return register captures the old `car_o`+1.
- R7: A call whose condition is false only increments `car_o`. The return register keeps its value.
- R8: With `br_type_i` = 2 (return), `car_o` loads the return register. The return register itself is not changed by a return.
- R9: Incrementing wraps from the top address (127) to 0. This applies to both the stepped address and the saved return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_type_i | input | 2 | Next-address kind: 0 jump, 1 call, 2 return, 3 map |
| cond_sel_i | input | 2 | Condition source: 0 always, 1 carry, 2 sign, 3 indirect |
| br_addr_i | input | 7 | Branch target field of the current microinstruction |
| status_i | input | 3 | Status flags {indirect, sign, carry} |
| opcode_i | input | 4 | Opcode bits from the instruction register |
| car_o | output | 7 | Control address register, drives control-memory address |

## Verification
The bench builds the sequencer with its default parameters: a 7-bit address, a 4-bit opcode, four words per routine and the fetch routine at 0. With these values the top address of 127 can be reached with a single jump, so the wrap to 0 can be checked both on a plain step and on the return address saved by a call placed at word 127. The opcode values 0, 11 and 15 place routine starts at 0, 44 and 60, which covers the lowest and highest mapped slots. A short microprogram held in a constant table then runs a fetch, a map and a branch back to fetch.

// File: rtl/mseq_pkg.sv
// Package: shared types for the microprogram next-address sequencer.
// Assumes the branch-type field of a microinstruction is two bits wide.
package mseq_pkg;

    // Kind of next-address selection coded in a microinstruction.
    typedef enum logic [1:0] {
        BT_JUMP = 2'd0,
        BT_CALL = 2'd1,
        BT_RET  = 2'd2,
        BT_MAP  = 2'd3
    } br_type_e;

endpackage

// File: rtl/mseq_cond_mux.sv
// Module: picks the branch condition from a constant one and NSTAT status flags.
// Assumes select value 0 means "always", and value k selects status bit k-1.
// Select values above NSTAT read as false.
module mseq_cond_mux #(
    parameter int NSTAT = 3,
    localparam int SEL_W = $clog2(NSTAT + 1)
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NSTAT-1:0] status_i,
    output logic             cond_o
);

    logic [NSTAT:0] cand;

    // Candidate vector: index 0 is the constant, the flags sit above it.
    assign cand = {status_i, 1'b1};

    // Steer one candidate onto the condition line.
    always_comb begin
        if (int'(sel_i) <= NSTAT) cond_o = cand[sel_i];
        else                      cond_o = 1'b0;
    end

endmodule

// File: rtl/mseq_map.sv
// Module: turns an opcode into the first control-memory address of its routine.
// Assumes ADDR_W >= OP_W + SLOT_W. The opcode sits above SLOT_W zero bits,
// and any spare high bits are zero.
module mseq_map #(
    parameter int ADDR_W = 7,
    parameter int OP_W   = 4,
    parameter int SLOT_W = 2
) (
    input  logic [OP_W-1:0]   opcode_i,
    output logic [ADDR_W-1:0] map_o
);

    localparam int PAD_W = ADDR_W - OP_W - SLOT_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // Opcode with zero padding above and a zero slot field below.
            assign map_o = {{PAD_W{1'b0}}, opcode_i, {SLOT_W{1'b0}}};
        end else begin : g_nopad
            // Address is exactly the opcode followed by the slot field.
            assign map_o = {opcode_i, {SLOT_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/mseq_next_sel.sv
// Module: combinational choice of the next control address and of the
// return-register load. Assumes the incremented address is given with wrap.
module mseq_next_sel
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  br_type_e          br_type_i,
    input  logic              cond_i,
    input  logic [ADDR_W-1:0] inc_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    input  logic [ADDR_W-1:0] map_i,
    input  logic [ADDR_W-1:0] ret_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              save_ret_o
);

    // Four-way next-address choice, with the condition gating jump and call.
    always_comb begin
        next_o     = inc_i;
        save_ret_o = 1'b0;
        unique case (br_type_i)
            BT_JUMP: if (cond_i) next_o = br_addr_i;
            BT_CALL: if (cond_i) begin
                next_o     = br_addr_i;
                save_ret_o = 1'b1;
            end
            BT_RET:  next_o = ret_i;
            BT_MAP:  next_o = map_i;
            default: next_o = inc_i;
        endcase
    end

endmodule

// File: rtl/mseq_next_addr.sv
// Module: top of the microprogram next-address sequencer. Holds the control
// address register and the single return register.
// Assumes a synchronous active-low reset and that the microinstruction fields
// are valid in every cycle.
module mseq_next_addr
    import mseq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int SLOT_W     = 2,
    parameter int NSTAT      = 3,
    parameter int FETCH_ADDR = 0,
    localparam int SEL_W     = $clog2(NSTAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        br_type_i,
    input  logic [SEL_W-1:0]  cond_sel_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    input  logic [NSTAT-1:0]  status_i,
    input  logic [OP_W-1:0]   opcode_i,
    output logic [ADDR_W-1:0] car_o
);

    localparam logic [ADDR_W-1:0] FETCH = ADDR_W'(FETCH_ADDR);

    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] car_inc;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] car_next;
    logic              cond_hit;
    logic              save_ret;

    // Incrementer, wrapping naturally at the register width.
    assign car_inc = car_q + ADDR_W'(1);

    mseq_cond_mux #(.NSTAT(NSTAT)) u_cond (
        .sel_i    (cond_sel_i),
        .status_i (status_i),
        .cond_o   (cond_hit)
    );

    mseq_map #(.ADDR_W(ADDR_W), .OP_W(OP_W), .SLOT_W(SLOT_W)) u_map (
        .opcode_i (opcode_i),
        .map_o    (map_addr)
    );

    mseq_next_sel #(.ADDR_W(ADDR_W)) u_sel (
        .br_type_i  (br_type_e'(br_type_i)),
        .cond_i     (cond_hit),
        .inc_i      (car_inc),
        .br_addr_i  (br_addr_i),
        .map_i      (map_addr),
        .ret_i      (ret_q),
        .next_o     (car_next),
        .save_ret_o (save_ret)
    );

    // Control address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= FETCH;
        else        car_q <= car_next;
    end

    // Return register: loads the following address only on a taken call.
    always_ff @(posedge clk) begin
        if (!rst_n)        ret_q <= FETCH;
        else if (save_ret) ret_q <= car_inc;
    end

    assign car_o = car_q;

endmodule

// File: rtl/mseq_chk.sv
// Module: assertion checker for the next-address sequencer, bound to the top.
// Assumes it can see the return register and the selected condition.
module mseq_chk #(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int SLOT_W     = 2,
    parameter int FETCH_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        br_type_i,
    input logic [ADDR_W-1:0] br_addr_i,
    input logic [OP_W-1:0]   opcode_i,
    input logic [ADDR_W-1:0] car_o,
    input logic [ADDR_W-1:0] ret_q,
    input logic              cond_hit
);

    logic was_rst = 1'b0;

    // Track whether the previous edge saw reset asserted.
    always @(posedge clk) begin
        if (was_rst) begin
            p_reset_fetch_r1: assert (car_o == ADDR_W'(FETCH_ADDR))
                else $error("car not at fetch after reset");
            p_reset_ret_r2: assert (ret_q == ADDR_W'(FETCH_ADDR))
                else $error("return register not at fetch after reset");
        end
        was_rst <= (rst_n === 1'b0);
    end

    p_jump_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_type_i == 2'd0 && cond_hit) |=> car_o == $past(br_addr_i));

    p_jump_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_type_i == 2'd0 && !cond_hit) |=> car_o == ADDR_W'($past(car_o) + 1'b1));

    p_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_type_i == 2'd3) |=> car_o == (ADDR_W'($past(opcode_i)) << SLOT_W));

    p_call_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_type_i == 2'd1 && cond_hit) |=> ret_q == ADDR_W'($past(car_o) + 1'b1));

    p_ret_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_type_i == 2'd1 && cond_hit) |=> $stable(ret_q));

    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_type_i == 2'd2) |=> car_o == $past(ret_q));

endmodule

bind mseq_next_addr mseq_chk #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .SLOT_W(SLOT_W), .FETCH_ADDR(FETCH_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_type_i (br_type_i),
    .br_addr_i (br_addr_i),
    .opcode_i  (opcode_i),
    .car_o     (car_o),
    .ret_q     (ret_q),
    .cond_hit  (cond_hit)
);

// File: tb/sim_mseq_next_addr.sv
// Directed bench for the next-address sequencer: one task per scenario.
module sim_mseq_next_addr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] br_type = 2'd0;
    logic [1:0] cond_sel = 2'd0;
    logic [6:0] br_addr = 7'd0;
    logic [2:0] status = 3'd0;
    logic [3:0] opcode = 4'd0;
    logic [6:0] car;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mseq_next_addr u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_type_i  (br_type),
        .cond_sel_i (cond_sel),
        .br_addr_i  (br_addr),
        .status_i   (status),
        .opcode_i   (opcode),
        .car_o      (car)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [6:0] exp);
        checks++;
        if (car !== exp) begin
            fails++;
            $display("FAIL %s: car_o=%0d expected %0d", req, car, exp);
        end
    endtask

    // Present one microinstruction, let one edge pass, sample at the falling edge.
    task automatic step(input logic [1:0] bt, input logic [1:0] sel,
                        input logic [6:0] addr, input logic [2:0] st,
                        input logic [3:0] op);
        br_type = bt; cond_sel = sel; br_addr = addr; status = st; opcode = op;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2'd0, 2'd0, 7'd99, 3'b111, 4'd5);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", 7'd0);
        step(2'd0, 2'd1, 7'd0, 3'b000, 4'd0);
        check("R1", 7'd1);
    endtask

    task automatic t_conditions();
        step(2'd0, 2'd0, 7'd10, 3'b000, 4'd0); check("R4", 7'd10);
        step(2'd0, 2'd1, 7'd90, 3'b110, 4'd0); check("R3", 7'd11);
        step(2'd0, 2'd1, 7'd20, 3'b001, 4'd0); check("R3", 7'd20);
        step(2'd0, 2'd2, 7'd30, 3'b010, 4'd0); check("R3", 7'd30);
        step(2'd0, 2'd2, 7'd90, 3'b101, 4'd0); check("R3", 7'd31);
        step(2'd0, 2'd3, 7'd40, 3'b100, 4'd0); check("R3", 7'd40);
        step(2'd0, 2'd3, 7'd90, 3'b011, 4'd0); check("R4", 7'd41);
    endtask

    task automatic t_map();
        step(2'd3, 2'd0, 7'd1, 3'b000, 4'hB); check("R5", 7'd44);
        step(2'd3, 2'd2, 7'd1, 3'b000, 4'hF); check("R5", 7'd60);
        step(2'd3, 2'd0, 7'd1, 3'b111, 4'h0); check("R5", 7'd0);
    endtask

    task automatic t_call_return();
        do_reset();
        step(2'd0, 2'd1, 7'd0, 3'b000, 4'd0);   // car 1
        step(2'd2, 2'd0, 7'd77, 3'b111, 4'd0); check("R2", 7'd0);
        step(2'd0, 2'd0, 7'd50, 3'b000, 4'd0); check("R4", 7'd50);
        step(2'd1, 2'd0, 7'd100, 3'b000, 4'd0); check("R6", 7'd100);
        step(2'd2, 2'd0, 7'd3, 3'b000, 4'd0);  check("R8", 7'd51);
        step(2'd1, 2'd1, 7'd5, 3'b000, 4'd0);  check("R7", 7'd52);
        step(2'd2, 2'd0, 7'd3, 3'b000, 4'd0);  check("R7", 7'd51);
        step(2'd0, 2'd1, 7'd0, 3'b000, 4'd0);  check("R4", 7'd52);
        step(2'd2, 2'd0, 7'd3, 3'b000, 4'd0);  check("R8", 7'd51);
    endtask

    task automatic t_wrap();
        step(2'd0, 2'd0, 7'd127, 3'b000, 4'd0); check("R4", 7'd127);
        step(2'd0, 2'd1, 7'd9, 3'b000, 4'd0);   check("R9", 7'd0);
        step(2'd0, 2'd0, 7'd127, 3'b000, 4'd0);
        step(2'd1, 2'd0, 7'd9, 3'b000, 4'd0);   check("R6", 7'd9);
        step(2'd2, 2'd0, 7'd33, 3'b000, 4'd0);  check("R9", 7'd0);
    endtask

    task automatic t_midrun_reset();
        step(2'd0, 2'd0, 7'd70, 3'b000, 4'd0);  check("R4", 7'd70);
        do_reset();
        check("R1", 7'd0);
    endtask

    // Constant microprogram: fetch at 0..1, routine of opcode 2 at 8, back to fetch.
    function automatic logic [13:0] rom(input logic [6:0] a);
        case (a)
            7'd0:    rom = {2'd0, 2'd1, 7'd0, 3'd0};   // step (carry clear)
            7'd1:    rom = {2'd3, 2'd0, 7'd0, 3'd0};   // map
            7'd8:    rom = {2'd0, 2'd1, 7'd0, 3'd0};   // step
            7'd9:    rom = {2'd0, 2'd0, 7'd0, 3'd0};   // branch to fetch
            default: rom = {2'd0, 2'd0, 7'd0, 3'd0};
        endcase
    endfunction

    task automatic t_program();
        logic [6:0] trace [0:4];
        trace[0] = 7'd1; trace[1] = 7'd8; trace[2] = 7'd9;
        trace[3] = 7'd0; trace[4] = 7'd1;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            logic [13:0] w;
            w = rom(car);
            step(w[13:12], w[11:10], w[9:3], 3'b000, 4'd2);
            check("R5", trace[i]);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_conditions();
        t_map();
        t_call_return();
        t_wrap();
        t_midrun_reset();
        t_program();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule